// File: doc/BRIEF.md
# Multi-Cycle Stage Sequencing Controller

This block is the control state machine of a processor core that runs each instruction over several clocks. Every instruction starts with instruction fetch and decode. It then passes through execute, and through memory access and register write-back when its class needs them. Each stage is held for its own fixed number of clocks, set by a parameter. A stage that the instruction class does not use is skipped, so short instructions finish in fewer clocks than long ones.

A single memory port serves both instruction fetch and data access. The controller tells the datapath which address source drives that port. It strobes the instruction register once per instruction, and it raises a one-clock done pulse on the final clock of each instruction. The datapath uses that pulse to commit the program counter and register writes. The decoded instruction class is taken in on the last decode clock only. Its value at any other time has no effect.

Top module: `mc_stage_seq`

## Requirements
- R1: With the default parameters, fetch lasts 2 clocks, decode 1, execute 2, memory access 2 and write-back 1. The stage code on `stage` is 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back.
- R2: An instruction of class 0 (load) visits fetch, decode, execute, memory and write-back in that order and takes 8 clocks.
- R3: An instruction of class 1 (store) skips write-back and takes 7 clocks.
- R4: An instruction of class 2 (register-type) skips memory access and takes 6 clocks.
- R5: An instruction of class 3 (branch) ends after execute and takes 5 clocks.
- R6: `mem_sel_data` is 1 (data address drives the shared memory) exactly during memory-access clocks. It is 0 (program counter drives it) on every other clock.
- R7: `ir_load` is high on the final fetch clock only, once per instruction.
- R8: `insn_done` is high for exactly one clock, the last clock of each instruction. The following clock is the first fetch clock of the next instruction.
- R9: `insn_class` is sampled only on the last decode clock. Changing it on any other clock does not alter the stage sequence of the instruction in flight.
- R10: While `rst` is high, and on the first clock after it, the controller sits on the first fetch clock. In that state only `fetch_en` is high, and `ir_load` and `insn_done` are low. A reset in the middle of an instruction abandons that instruction.
- R11: On every clock exactly one of `fetch_en`, `dec_en`, `exec_en`, `mem_en`, `wb_en` is high, and it matches `stage`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_class | input | 2 | Decoded class: 0 load, 1 store, 2 register-type, 3 branch |
| stage | output | 3 | Current stage code |
| fetch_en | output | 1 | Fetch stage active |
| dec_en | output | 1 | Decode stage active |
| exec_en | output | 1 | Execute stage active |
| mem_en | output | 1 | Memory-access stage active |
| wb_en | output | 1 | Write-back stage active |
| ir_load | output | 1 | Instruction register load strobe |
| mem_sel_data | output | 1 | Shared memory address source: 1 data, 0 instruction |
| insn_done | output | 1 | Last clock of the instruction; commit state |

## Verification
All outputs decode directly from the stage register, so each one is valid in the same clock the state is entered. The bench samples them on the falling edge of that clock. The class input is taken on the rising edge that ends the decode clock, which is clock index 2 of an instruction. The new sequence therefore shows from index 3 onward. The bench changes the class only at index 3 or later, so it can show that late changes are ignored. A reset asserted on one falling edge takes effect at the next rising edge, and the bench checks the reset state on the falling edge after that.

// File: rtl/mc_stage_seq.sv
module mc_stage_seq #(
  parameter int FETCH_CLKS = 2,
  parameter int DEC_CLKS   = 1,
  parameter int EXEC_CLKS  = 2,
  parameter int MEM_CLKS   = 2,
  parameter int WB_CLKS    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] insn_class,
  output logic [2:0] stage,
  output logic       fetch_en,
  output logic       dec_en,
  output logic       exec_en,
  output logic       mem_en,
  output logic       wb_en,
  output logic       ir_load,
  output logic       mem_sel_data,
  output logic       insn_done
);

  localparam int M1   = FETCH_CLKS > DEC_CLKS ? FETCH_CLKS : DEC_CLKS;
  localparam int M2   = EXEC_CLKS > MEM_CLKS ? EXEC_CLKS : MEM_CLKS;
  localparam int M3   = M1 > M2 ? M1 : M2;
  localparam int MAXC = M3 > WB_CLKS ? M3 : WB_CLKS;
  localparam int CW   = MAXC > 1 ? $clog2(MAXC) : 1;

  localparam logic [2:0] ST_F = 3'd0;
  localparam logic [2:0] ST_D = 3'd1;
  localparam logic [2:0] ST_E = 3'd2;
  localparam logic [2:0] ST_M = 3'd3;
  localparam logic [2:0] ST_W = 3'd4;

  localparam logic [1:0] CL_LOAD  = 2'd0;
  localparam logic [1:0] CL_STORE = 2'd1;
  localparam logic [1:0] CL_REG   = 2'd2;
  localparam logic [1:0] CL_BR    = 2'd3;

  logic [2:0]    stage_q, stage_nx;
  logic [CW-1:0] cnt_q, last_cnt;
  logic [1:0]    cls_q;
  logic          last;

  always_comb begin
    case (stage_q)
      ST_F:    last_cnt = CW'(FETCH_CLKS - 1);
      ST_D:    last_cnt = CW'(DEC_CLKS - 1);
      ST_E:    last_cnt = CW'(EXEC_CLKS - 1);
      ST_M:    last_cnt = CW'(MEM_CLKS - 1);
      default: last_cnt = CW'(WB_CLKS - 1);
    endcase
  end

  assign last = (cnt_q == last_cnt);

  always_comb begin
    case (stage_q)
      ST_F:    stage_nx = ST_D;
      ST_D:    stage_nx = ST_E;
      ST_E:    stage_nx = (cls_q == CL_BR)  ? ST_F :
                          (cls_q == CL_REG) ? ST_W : ST_M;
      ST_M:    stage_nx = (cls_q == CL_STORE) ? ST_F : ST_W;
      default: stage_nx = ST_F;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_F;
      cnt_q   <= '0;
      cls_q   <= CL_LOAD;
    end else begin
      if (stage_q == ST_D && last) cls_q <= insn_class;
      if (last) begin
        stage_q <= stage_nx;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign stage        = stage_q;
  assign fetch_en     = (stage_q == ST_F);
  assign dec_en       = (stage_q == ST_D);
  assign exec_en      = (stage_q == ST_E);
  assign mem_en       = (stage_q == ST_M);
  assign wb_en        = (stage_q == ST_W);
  assign ir_load      = fetch_en && last;
  assign mem_sel_data = mem_en;
  assign insn_done    = last && !fetch_en && (stage_nx == ST_F);

endmodule

// File: rtl/mc_stage_seq_chk.sv
module mc_stage_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] stage,
  input logic       fetch_en,
  input logic       dec_en,
  input logic       exec_en,
  input logic       mem_en,
  input logic       wb_en,
  input logic       ir_load,
  input logic       mem_sel_data,
  input logic       insn_done
);

  // R11
  one_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({fetch_en, dec_en, exec_en, mem_en, wb_en}) == 1);

  // R6
  mem_port_chk: assert property (@(posedge clk) disable iff (rst)
    mem_sel_data |-> (mem_en && stage == 3'd3));

  // R7
  ir_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (dec_en && !ir_load));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    insn_done |=> (fetch_en && !insn_done && !ir_load));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stage == 3'd0 && fetch_en && !insn_done && !ir_load));

  // R8
  done_not_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    insn_done |-> !fetch_en);

endmodule

bind mc_stage_seq mc_stage_seq_chk chk_i (
  .clk(clk), .rst(rst), .stage(stage),
  .fetch_en(fetch_en), .dec_en(dec_en), .exec_en(exec_en),
  .mem_en(mem_en), .wb_en(wb_en), .ir_load(ir_load),
  .mem_sel_data(mem_sel_data), .insn_done(insn_done)
);

// File: tb/mc_stage_seq_tb.sv
module mc_stage_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // each entry: {class[1:0], expected clocks[3:0]}
  localparam logic [5:0] VEC [NVEC] = '{
    {2'd0, 4'd8}, {2'd1, 4'd7}, {2'd2, 4'd6}, {2'd3, 4'd5},
    {2'd3, 4'd5}, {2'd0, 4'd8}, {2'd2, 4'd6}, {2'd1, 4'd7}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] insn_class = 2'd0;
  logic [2:0] stage;
  logic fetch_en, dec_en, exec_en, mem_en, wb_en, ir_load, mem_sel_data, insn_done;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_stage_seq dut_i (
    .clk(clk), .rst(rst), .insn_class(insn_class), .stage(stage),
    .fetch_en(fetch_en), .dec_en(dec_en), .exec_en(exec_en),
    .mem_en(mem_en), .wb_en(wb_en), .ir_load(ir_load),
    .mem_sel_data(mem_sel_data), .insn_done(insn_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at time %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stage(input logic [1:0] cls, input int k);
    if (k < 2) return 3'd0;
    if (k == 2) return 3'd1;
    if (k < 5) return 3'd2;
    case (cls)
      2'd0:    return (k < 7) ? 3'd3 : 3'd4;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic string cls_req(input logic [1:0] cls);
    case (cls)
      2'd0:    return "R2/R1 load stage";
      2'd1:    return "R3 store stage";
      2'd2:    return "R4 reg stage";
      default: return "R5 branch stage";
    endcase
  endfunction

  // Called at a falling edge on clock 0 of an instruction; returns at clock 0 of the next.
  task automatic run_insn(input logic [1:0] cls, input int n, input logic [1:0] late_cls,
                          input string tag);
    insn_class = cls;
    for (int k = 0; k < n; k++) begin
      logic [2:0] es;
      logic [4:0] een;
      es  = exp_stage(cls, k);
      een = 5'b00001 << es;
      chk(stage == es, {tag, " ", cls_req(cls)}, stage, es);
      chk({wb_en, mem_en, exec_en, dec_en, fetch_en} == een, "R11 enables",
          {wb_en, mem_en, exec_en, dec_en, fetch_en}, een);
      chk(mem_sel_data == (es == 3'd3), "R6 memory select", mem_sel_data, es == 3'd3);
      chk(ir_load == (k == 1), "R7 ir load", ir_load, k == 1);
      chk(insn_done == (k == n - 1), "R8 done pulse", insn_done, k == n - 1);
      @(negedge clk);
      if (k == 2) insn_class = late_cls;
    end
    chk(fetch_en && !insn_done, "R8 next is fetch", fetch_en, 1);
  endtask

  task automatic chk_reset_state();
    chk(stage == 3'd0, "R10 reset stage", stage, 0);
    chk({wb_en, mem_en, exec_en, dec_en, fetch_en} == 5'b00001, "R10 reset enables",
        {wb_en, mem_en, exec_en, dec_en, fetch_en}, 1);
    chk(!ir_load && !insn_done && !mem_sel_data, "R10 reset strobes",
        {ir_load, insn_done, mem_sel_data}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog expired: actual %0d cycles expected under 5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    // R10: first clock after reset is clock 0 of fetch
    chk_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] c;
      c = VEC[i][5:4];
      run_insn(c, int'(VEC[i][3:0]), c, "table");
    end

    // R9: class changes after decode are ignored
    run_insn(2'd0, 8, 2'd3, "R9 late branch");
    run_insn(2'd3, 5, 2'd0, "R9 late load");
    run_insn(2'd1, 7, 2'd2, "R9 late reg");

    // R10: reset in the middle of execute abandons the instruction
    insn_class = 2'd0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    chk_reset_state();
    run_insn(2'd2, 6, 2'd2, "R10 after reset");
    run_insn(2'd0, 8, 2'd0, "R1 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule